// File: doc/BRIEF.md
# Strided Burst Memory Port

This block is a memory port in front of a word-addressed on-chip RAM. Requests arrive on valid/ready channels. A command channel carries an address and a two-bit operation kind. Separate channels carry write data, a stride, a word count and a packed fetch descriptor. Every result leaves on one valid/ready output channel: read data, or a zero-valued token confirming that a write has been committed.

Single reads and writes are served directly from the command channel. A burst command latches a start address, a stride and a count. The block then walks the RAM one beat at a time, adding the stride after each beat, until the count runs out. New commands wait until the burst is over. A descriptor word is shorthand for a burst read with unit stride. It is used to pull a block of consecutive words out of the RAM.

The RAM has one cycle of read latency. Results pass through a registered output stage, so the consumer may stall the output channel for as long as it likes without any word being lost.

Top module: `strided_mem_port`

## Requirements
- R1: A command with kind 0 (single read) returns, as one output word, the RAM word at the command address.
- R2: A command with kind 1 (single write) is accepted only together with a write-data word. It stores that word at the command address and then emits exactly one output word of value zero.
- R3: A descriptor word carries a count in bits [5:0] and a base address in bits [AW+5:6]. Bits above the base address are ignored. The descriptor runs as a burst read from the base address with stride 1 and that count.
- R4: A command with kind 2 (burst read) or kind 3 (burst write) is accepted only when the command, stride and count channels are all valid. All three are consumed in the same cycle.
- R5: Each burst beat uses the current address and then advances it by the stride, modulo 2^AW. A burst produces exactly as many beats as its count, in address-sequence order.
- R6: A burst-write beat consumes one write-data word, stores it at the current address and emits one zero-valued output word. While no write data is offered, no beat and no output word occur.
- R7: While a burst is in progress, the command channel is not ready.
- R8: While the output is valid and not accepted, its data stays unchanged. No result is dropped or reordered.
- R9: A burst or descriptor with count zero produces no output word, and the block is idle again on the next cycle.
- R10: When a descriptor and a command are both offered while the block is idle, the descriptor is taken first and the command waits.
- R11: During reset and immediately after reset release, the output channel is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_kind | input | 2 | 0 read, 1 write, 2 burst read, 3 burst write |
| cmd_addr | input | AW (10) | Word address or burst start address |
| wd_valid | input | 1 | Write-data word offered |
| wd_ready | output | 1 | Write-data word accepted |
| wd_data | input | DW (32) | Write-data word |
| str_valid | input | 1 | Stride offered |
| str_ready | output | 1 | Stride accepted |
| str_data | input | AW (10) | Address increment per beat |
| cnt_valid | input | 1 | Count offered |
| cnt_ready | output | 1 | Count accepted |
| cnt_data | input | CW (16) | Number of beats |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted |
| desc_data | input | DW (32) | Packed base address and count |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DW (32) | Read data, or zero for a write token |

## Verification
The assertions check several properties on every cycle. No command is accepted while a burst runs, and a descriptor beats a waiting command. Burst acceptance only ever happens with stride and count present, the address advances by the latched stride on every beat, and a burst only ends from a count of one. A zero count leaves the block idle, a stalled output word stays still, a freshly read word never lands on a word not yet taken, and a write token always carries zero. Only the bench can show that the data is correct: that each read returns what an earlier write or burst stored, including after address wrap and with stride zero. It also shows that descriptor fields are decoded correctly, that results keep their order under random backpressure, and that a write burst waits for its data.

// File: rtl/smp_pkg.sv
package smp_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_BREAD  = 2'd2,
    OP_BWRITE = 2'd3
  } op_e;

endpackage

// File: rtl/smp_rst_sync.sv
module smp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/smp_ram.sv
module smp_ram #(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (en && we)  mem[addr] <= wdata;
    if (en && !we) q <= mem[addr];
  end

  assign rdata = q;

endmodule

// File: rtl/smp_out_stage.sv
module smp_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          issue_ack,
  input  logic [DW-1:0] ram_q,
  output logic          slot_ok,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic          pend_q, pend_n;
  logic          ack_q, ack_n;
  logic          vld_q, vld_n;
  logic [DW-1:0] dat_q, dat_n;
  logic          dat_en;

  always_comb begin
    slot_ok = !pend_q && (!vld_q || out_ready);
    pend_n  = issue;
    ack_n   = issue_ack;
    if (pend_q)         vld_n = 1'b1;
    else if (out_ready) vld_n = 1'b0;
    else                vld_n = vld_q;
    dat_en = pend_q;
    dat_n  = ack_q ? '0 : ram_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      ack_q  <= ack_n;
      vld_q  <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= dat_n;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (!vld_q || out_ready));

  p_ack_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ack_q) |=> (out_valid && out_data == '0));

endmodule

// File: rtl/smp_burst_seq.sv
module smp_burst_seq
  import smp_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 10,
  parameter int CW  = 16,
  parameter int SZW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [DW-1:0] wd_data,
  input  logic          str_valid,
  output logic          str_ready,
  input  logic [AW-1:0] str_data,
  input  logic          cnt_valid,
  output logic          cnt_ready,
  input  logic [CW-1:0] cnt_data,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [DW-1:0] desc_data,
  input  logic          slot_ok,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          issue,
  output logic          issue_ack
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] STR_ONE = AW'(1);

  logic          busy_q, busy_n;
  logic          wr_q, wr_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [AW-1:0] stride_q, stride_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          st_en;

  logic          idle, cmd_free;
  logic          take_desc, rd_go, wr_go, burst_go, beat_rd, beat_wr;
  logic [CW-1:0] desc_cnt;
  logic [AW-1:0] desc_base;
  op_e           kind;

  always_comb begin
    kind      = op_e'(cmd_kind);
    idle      = !busy_q;
    cmd_free  = idle && !desc_valid && cmd_valid;
    take_desc = idle && desc_valid;
    rd_go     = cmd_free && (kind == OP_READ) && slot_ok;
    wr_go     = cmd_free && (kind == OP_WRITE) && wd_valid && slot_ok;
    burst_go  = cmd_free && cmd_kind[1] && str_valid && cnt_valid;
    beat_rd   = busy_q && !wr_q && slot_ok;
    beat_wr   = busy_q && wr_q && wd_valid && slot_ok;
    desc_cnt  = {{(CW-SZW){1'b0}}, desc_data[SZW-1:0]};
    desc_base = desc_data[SZW+AW-1:SZW];

    cmd_ready  = rd_go || wr_go || burst_go;
    str_ready  = burst_go;
    cnt_ready  = burst_go;
    desc_ready = take_desc;
    wd_ready   = wr_go || beat_wr;

    ram_en    = rd_go || wr_go || beat_rd || beat_wr;
    ram_we    = wr_go || beat_wr;
    ram_addr  = busy_q ? addr_q : cmd_addr;
    ram_wdata = wd_data;
    issue     = ram_en;
    issue_ack = ram_we;
  end

  always_comb begin
    busy_n   = busy_q;
    wr_n     = wr_q;
    addr_n   = addr_q;
    stride_n = stride_q;
    cnt_n    = cnt_q;
    st_en    = 1'b0;
    if (take_desc) begin
      st_en    = 1'b1;
      busy_n   = (desc_cnt != '0);
      wr_n     = 1'b0;
      addr_n   = desc_base;
      stride_n = STR_ONE;
      cnt_n    = desc_cnt;
    end else if (burst_go) begin
      st_en    = 1'b1;
      busy_n   = (cnt_data != '0);
      wr_n     = (kind == OP_BWRITE);
      addr_n   = cmd_addr;
      stride_n = str_data;
      cnt_n    = cnt_data;
    end else if (beat_rd || beat_wr) begin
      st_en    = 1'b1;
      busy_n   = (cnt_q != CNT_ONE);
      addr_n   = addr_q + stride_q;
      cnt_n    = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      cnt_q    <= '0;
    end else if (st_en) begin
      busy_q   <= busy_n;
      wr_q     <= wr_n;
      addr_q   <= addr_n;
      stride_q <= stride_n;
      cnt_q    <= cnt_n;
    end
  end

  p_no_cmd_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !cmd_ready);

  p_desc_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !busy_q) |-> (desc_ready && !cmd_ready));

  p_burst_join_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind[1]) |-> (str_valid && cnt_valid && str_ready && cnt_ready));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ram_en) |=> (addr_q == $past(addr_q + stride_q)));

  p_burst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == CNT_ONE));

  p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_go && cnt_data == '0) |=> !busy_q);

  p_wdata_needs_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_q && !wd_valid) |-> !ram_en);

endmodule

// File: rtl/strided_mem_port.sv
module strided_mem_port #(
  parameter int DW  = 32,
  parameter int AW  = 10,
  parameter int CW  = 16,
  parameter int SZW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [DW-1:0] wd_data,
  input  logic          str_valid,
  output logic          str_ready,
  input  logic [AW-1:0] str_data,
  input  logic          cnt_valid,
  output logic          cnt_ready,
  input  logic [CW-1:0] cnt_data,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [DW-1:0] desc_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic          rst_s_n;
  logic          slot_ok;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_q;
  logic          issue, issue_ack;

  smp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  smp_burst_seq #(.DW(DW), .AW(AW), .CW(CW), .SZW(SZW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_kind   (cmd_kind),
    .cmd_addr   (cmd_addr),
    .wd_valid   (wd_valid),
    .wd_ready   (wd_ready),
    .wd_data    (wd_data),
    .str_valid  (str_valid),
    .str_ready  (str_ready),
    .str_data   (str_data),
    .cnt_valid  (cnt_valid),
    .cnt_ready  (cnt_ready),
    .cnt_data   (cnt_data),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_data  (desc_data),
    .slot_ok    (slot_ok),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .issue      (issue),
    .issue_ack  (issue_ack)
  );

  smp_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_q)
  );

  smp_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .issue     (issue),
    .issue_ack (issue_ack),
    .ram_q     (ram_q),
    .slot_ok   (slot_ok),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_s_n |=> !out_valid);

endmodule

// File: tb/strided_mem_port_tb.sv
module strided_mem_port_tb;

  localparam int DW = 32;
  localparam int AW = 10;
  localparam int CW = 16;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_kind = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic wd_valid = 1'b0, wd_ready;
  logic [DW-1:0] wd_data = '0;
  logic str_valid = 1'b0, str_ready;
  logic [AW-1:0] str_data = '0;
  logic cnt_valid = 1'b0, cnt_ready;
  logic [CW-1:0] cnt_data = '0;
  logic desc_valid = 1'b0, desc_ready;
  logic [DW-1:0] desc_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [DW-1:0] out_data;

  logic [DW-1:0] mem_m [DEPTH];
  exp_t exp_q [$];
  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0, hold_lo = 1'b0, done = 1'b0;
  int rdy_pct = 100;
  logic [DW-1:0] prev_data = '0;
  bit prev_stall = 1'b0;

  always #4 clk = ~clk;

  strided_mem_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .str_valid(str_valid), .str_ready(str_ready), .str_data(str_data),
    .cnt_valid(cnt_valid), .cnt_ready(cnt_ready), .cnt_data(cnt_data),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [AW-1:0] step_addr(int unsigned a, int unsigned s, int unsigned i);
    return AW'((a + i * s) % DEPTH);
  endfunction

  // consumer side: random readiness, compare in order at the negative edge
  always begin
    @(posedge clk);
    #1 out_ready = hold_lo ? 1'b0 : (($urandom % 100) < rdy_pct);
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_stall && out_valid)
        chk(out_data === prev_data, "R8 stalled word changed", out_data, prev_data);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected output word", out_data, '0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(out_data === e.d, e.tag, out_data, e.d);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic wait_cmd_accept();
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk);
    #2;
    cmd_valid = 1'b0; str_valid = 1'b0; cnt_valid = 1'b0; wd_valid = 1'b0;
  endtask

  task automatic do_read(int unsigned a);
    exp_q.push_back('{mem_m[a % DEPTH], "R1 single read"});
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_addr = AW'(a);
    wait_cmd_accept();
  endtask

  task automatic do_write(int unsigned a, logic [DW-1:0] d);
    mem_m[a % DEPTH] = d;
    exp_q.push_back('{'0, "R2 write token"});
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_kind = 2'd1; cmd_addr = AW'(a);
    wd_valid = 1'b1; wd_data = d;
    wait_cmd_accept();
  endtask

  task automatic send_wd(logic [DW-1:0] d, int gap);
    repeat (gap) @(posedge clk);
    @(posedge clk); #2;
    wd_valid = 1'b1; wd_data = d;
    do @(negedge clk); while (!wd_ready);
    @(posedge clk); #2;
    wd_valid = 1'b0;
  endtask

  task automatic start_burst(bit wr, int unsigned a, int unsigned s, int unsigned c);
    if (!wr)
      for (int i = 0; i < c; i++)
        exp_q.push_back('{mem_m[step_addr(a, s, i)], "R5 burst read beat"});
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_kind = wr ? 2'd3 : 2'd2; cmd_addr = AW'(a);
    str_valid = 1'b1; str_data = AW'(s);
    cnt_valid = 1'b1; cnt_data = CW'(c);
  endtask

  task automatic do_burst(bit wr, int unsigned a, int unsigned s, int unsigned c, int max_gap);
    start_burst(wr, a, s, c);
    wait_cmd_accept();
    if (wr)
      for (int i = 0; i < c; i++) begin
        logic [DW-1:0] d;
        d = $urandom;
        mem_m[step_addr(a, s, i)] = d;
        exp_q.push_back('{'0, "R6 burst write token"});
        send_wd(d, (max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0);
      end
  endtask

  function automatic logic [DW-1:0] make_desc(int unsigned base, int unsigned size);
    logic [DW-1:0] w;
    w = $urandom;
    w[5:0] = 6'(size);
    w[AW+5:6] = AW'(base);
    return w;
  endfunction

  task automatic push_desc_exp(int unsigned base, int unsigned size);
    for (int i = 0; i < size; i++)
      exp_q.push_back('{mem_m[(base + i) % DEPTH], "R3 descriptor beat"});
  endtask

  task automatic do_desc(int unsigned base, int unsigned size);
    push_desc_exp(base, size);
    @(posedge clk); #2;
    desc_valid = 1'b1; desc_data = make_desc(base, size);
    do @(negedge clk); while (!desc_ready);
    @(posedge clk); #2;
    desc_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 out_valid in reset", {31'b0, out_valid}, '0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0, "R11 out_valid after release", {31'b0, out_valid}, '0);
    repeat (3) @(posedge clk);
    mon_on = 1'b1;

    // fill whole RAM with one long unit-stride burst write (R6, R5)
    do_burst(1'b1, 0, 1, DEPTH, 0);
    drain();

    // directed: singles (R1, R2)
    do_write(17, 32'hA5A5_0017);
    do_read(17);
    do_read(0);
    do_read(DEPTH - 1);
    drain();

    // R4: burst kind waits for count channel
    start_burst(1'b0, 40, 5, 3);
    cnt_valid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(cmd_ready === 1'b0, "R4 burst taken without count", {31'b0, cmd_ready}, '0);
    end
    @(posedge clk); #2;
    cnt_valid = 1'b1;
    wait_cmd_accept();
    drain();

    // R6 + R5 wrap: write burst near the top, data withheld for a while
    start_burst(1'b1, DEPTH - 2, 2, 3);
    wait_cmd_accept();
    repeat (5) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R6 token without write data", {31'b0, out_valid}, '0);
    end
    for (int i = 0; i < 3; i++) begin
      logic [DW-1:0] d;
      d = 32'hC0DE_0000 + i;
      mem_m[step_addr(DEPTH - 2, 2, i)] = d;
      exp_q.push_back('{'0, "R6 burst write token"});
      send_wd(d, 1);
    end
    drain();
    do_burst(1'b0, DEPTH - 2, 2, 3, 0);
    do_read(0);
    do_read(2);
    drain();

    // R7: command held off while a stalled burst runs
    hold_lo = 1'b1;
    start_burst(1'b0, 100, 3, 4);
    wait_cmd_accept();
    exp_q.push_back('{mem_m[9], "R7 read after burst"});
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_addr = AW'(9);
    repeat (6) begin
      @(negedge clk);
      chk(cmd_ready === 1'b0, "R7 command taken during burst", {31'b0, cmd_ready}, '0);
    end
    hold_lo = 1'b0;
    wait_cmd_accept();
    drain();

    // R9: zero-count burst and descriptor
    do_burst(1'b0, 5, 1, 0, 0);
    do_desc(77, 0);
    repeat (6) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R9 output from zero count", {31'b0, out_valid}, '0);
    end
    do_read(5);
    drain();

    // R10: descriptor and command offered together
    push_desc_exp(200, 2);
    exp_q.push_back('{mem_m[7], "R10 command after descriptor"});
    @(posedge clk); #2;
    desc_valid = 1'b1; desc_data = make_desc(200, 2);
    cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_addr = AW'(7);
    @(negedge clk);
    chk(desc_ready === 1'b1 && cmd_ready === 1'b0, "R10 priority",
        {30'b0, desc_ready, cmd_ready}, 32'h2);
    @(posedge clk); #2;
    desc_valid = 1'b0;
    wait_cmd_accept();
    drain();

    // R3: largest descriptor, wrapping past the top address
    do_desc(DEPTH - 10, 63);
    drain();

    // random mix under backpressure
    rdy_pct = 60;
    for (int n = 0; n < 90; n++) begin
      int unsigned k, a;
      k = $urandom % 5;
      a = $urandom % DEPTH;
      case (k)
        0: do_read(a);
        1: do_write(a, $urandom);
        2: do_burst(1'b0, a, $urandom % DEPTH, $urandom % 7, 0);
        3: do_burst(1'b1, a, $urandom % 4, $urandom % 7, 2);
        default: do_desc(a, $urandom % 9);
      endcase
    end
    rdy_pct = 100;
    drain();
    summary();
  end

endmodule